// File: doc/BRIEF.md
# I2C Bus Master with Byte FIFOs

This block is a single-master I2C engine controlled through a small write-only control word and two byte FIFOs, each sixteen deep. Software loads an address byte and payload bytes into the transmit FIFO. It then raises the master-mode bit in the control word. The engine issues a START and clocks the bytes out most significant bit first, with SDA changing only while SCL is low. In the receive direction it clocks bytes from the bus into the receive FIFO, and it drives the acknowledge slot with a level that software chooses.

SCL and SDA are open-drain lines. The block pulls a line low by raising its output-enable, and it reads the wired level back through the line inputs. Each SCL half period lasts `HALF_DIV` clock cycles. A bus monitor watches for START and STOP conditions from any master and keeps a bus-busy flag.

A transfer ends when software clears the master-mode bit, which produces a STOP. If another master wins arbitration, the engine clears the mode bit on its own, lets go of both lines and does not produce a STOP.

Top module: `i2c_fifo_master`

## Requirements
- R1: A control write with bit 0 (enable) at 0 puts no START on the bus and does not set `master_on`, whatever value bit 1 (master mode) carries. Such a write also returns an active engine to idle at once, with both lines released and `master_on` low.
- R2: A control write with enable = 1 and bit 1 changing from 0 to 1 raises `master_on` and issues a START, meaning SDA is pulled low while SCL is released. The engine then clocks the bytes from the transmit FIFO onto the bus, most significant bit first.
- R3: When software writes bit 1 = 0 while `master_on` is 1, the engine finishes the byte in flight and its acknowledge slot, then issues one STOP (SDA rises while SCL is high), and `master_on` reads 0.
- R4: When the engine releases SDA to send a 1 but reads SDA low during that SCL high phase, it clears `master_on`, releases both lines and issues no STOP.
- R5: In the acknowledge slot of a received byte, SDA is pulled low when control bit 3 is 0 and left released (NACK) when bit 3 is 1.
- R6: Control bit 2 alone sets the direction of the data bytes that follow the address (1 = transmit, 0 = receive), whatever the least significant bit of the address byte. Each received byte is assembled MSB first and pushed into the receive FIFO.
- R7: A control write with enable = 1 and bit 4 = 1 discards everything held in the transmit FIFO, so `tx_empty` reads 1.
- R8: `bus_busy` goes to 1 after a START is seen on the lines and back to 0 after a STOP is seen, including conditions driven by another master.
- R9: `tx_full` and `rx_full` assert only when all 16 entries are occupied, and `tx_empty` and `rx_empty` assert when no entry is occupied. While `rx_full` is 1 the engine holds SCL low and does not start another receive byte.
- R10: In the transmit direction with an empty transmit FIFO, the engine holds SCL low after the acknowledge slot until a byte is written or the master-mode bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 5 | Control word: [0] enable, [1] master mode, [2] transmit direction, [3] acknowledge level, [4] transmit FIFO flush |
| tx_push | input | 1 | Write one byte into the transmit FIFO |
| tx_byte | input | 8 | Byte to write into the transmit FIFO |
| rx_pop | input | 1 | Remove the head byte from the receive FIFO |
| rx_byte | output | 8 | Head byte of the receive FIFO |
| tx_empty | output | 1 | Transmit FIFO holds no byte |
| tx_full | output | 1 | Transmit FIFO holds 16 bytes |
| rx_empty | output | 1 | Receive FIFO holds no byte |
| rx_full | output | 1 | Receive FIFO holds 16 bytes |
| bus_busy | output | 1 | A START has been seen and no STOP since |
| master_on | output | 1 | Current value of the master-mode bit |
| scl_in | input | 1 | Wired level of SCL |
| sda_in | input | 1 | Wired level of SDA |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
Arbitration loss is the hardest case to reach, because it needs a second agent on SDA that pulls the line low exactly while the engine is sending a 1. In the bench, a bus model acting as a slave pulls SDA low on the first address bit. After the engine drops out, the bench releases SDA while SCL is high, which acts as the foreign STOP that clears the busy flag. The receive-full stall is also hard to reach. It takes sixteen back-to-back read bytes, so the slave model answers a long read and the bench only drains the FIFO after the engine has been seen holding SCL low.

// File: rtl/i2c_fm_pkg.sv
package i2c_fm_pkg;

    // control word bit positions
    localparam int CTL_W    = 5;
    localparam int CB_EN    = 0;
    localparam int CB_MS    = 1;
    localparam int CB_DIR   = 2;
    localparam int CB_ACK   = 3;
    localparam int CB_FLUSH = 4;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_LOAD  = 3'd2,
        ST_BIT   = 3'd3,
        ST_ACK   = 3'd4,
        ST_STOP  = 3'd5
    } eng_st_e;

endpackage

// File: rtl/i2c_fm_fifo.sv
module i2c_fm_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [WIDTH-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign full    = (ptr_q.cnt == CW'(DEPTH));
    assign empty   = (ptr_q.cnt == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign rdata   = mem[ptr_q.rp];

    always_comb begin
        ptr_d = ptr_q;
        if (flush) begin
            ptr_d = '0;
        end else begin
            if (do_push) ptr_d.wp = (ptr_q.wp == LAST) ? '0 : ptr_q.wp + AW'(1);
            if (do_pop)  ptr_d.rp = (ptr_q.rp == LAST) ? '0 : ptr_q.rp + AW'(1);
            case ({do_push, do_pop})
                2'b10:   ptr_d.cnt = ptr_q.cnt + CW'(1);
                2'b01:   ptr_d.cnt = ptr_q.cnt - CW'(1);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[ptr_q.wp] <= wdata;
    end

endmodule

// File: rtl/i2c_fm_busmon.sv
module i2c_fm_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic busy
);
    typedef struct packed {
        logic scl;
        logic sda;
        logic busy;
    } mon_t;

    localparam mon_t MON_RST = '{scl: 1'b1, sda: 1'b1, busy: 1'b0};

    mon_t mon_d, mon_q;

    always_comb begin
        mon_d     = mon_q;
        mon_d.scl = scl;
        mon_d.sda = sda;
        if (mon_q.scl && scl && mon_q.sda && !sda)      mon_d.busy = 1'b1;
        else if (mon_q.scl && scl && !mon_q.sda && sda) mon_d.busy = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mon_q <= MON_RST;
        else        mon_q <= mon_d;
    end

    assign busy = mon_q.busy;

endmodule

// File: rtl/i2c_fifo_master.sv
module i2c_fifo_master
    import i2c_fm_pkg::*;
#(
    parameter int HALF_DIV   = 125,
    parameter int FIFO_DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             tx_push,
    input  logic [7:0]       tx_byte,
    input  logic             rx_pop,
    output logic [7:0]       rx_byte,
    output logic             tx_empty,
    output logic             tx_full,
    output logic             rx_empty,
    output logic             rx_full,
    output logic             bus_busy,
    output logic             master_on,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             sda_oe
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

    typedef struct packed {
        eng_st_e       st;
        logic [1:0]    half;
        logic [2:0]    bitn;
        logic [7:0]    sh;
        logic          addr_ph;
        logic          rcv;
        logic          mode;
        logic          dir;
        logic          ackv;
        logic [DW-1:0] div;
    } eng_t;

    eng_t eng_d, eng_q;
    logic tick, tx_pop, rx_push, tx_flush;
    logic [7:0] tx_head;

    i2c_fm_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txf (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push(tx_push), .wdata(tx_byte),
        .pop(tx_pop), .rdata(tx_head), .full(tx_full), .empty(tx_empty)
    );

    i2c_fm_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxf (
        .clk(clk), .rst_n(rst_n), .flush(1'b0), .push(rx_push), .wdata(eng_q.sh),
        .pop(rx_pop), .rdata(rx_byte), .full(rx_full), .empty(rx_empty)
    );

    i2c_fm_busmon u_mon (
        .clk(clk), .rst_n(rst_n), .scl(scl_in), .sda(sda_in), .busy(bus_busy)
    );

    always_comb begin
        eng_d   = eng_q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        tick    = (eng_q.div == DIV_LAST);

        if (eng_q.st == ST_IDLE || eng_q.st == ST_LOAD || tick) eng_d.div = '0;
        else                                                  eng_d.div = eng_q.div + DW'(1);

        case (eng_q.st)
            ST_START: if (tick) begin
                eng_d.st      = ST_LOAD;
                eng_d.addr_ph = 1'b1;
            end
            ST_LOAD: begin
                if (!eng_q.mode) begin
                    eng_d.st   = ST_STOP;
                    eng_d.half = 2'd0;
                end else if (eng_q.addr_ph || eng_q.dir) begin
                    if (!tx_empty) begin
                        eng_d.sh   = tx_head;
                        tx_pop     = 1'b1;
                        eng_d.rcv  = 1'b0;
                        eng_d.bitn = 3'd7;
                        eng_d.half = 2'd0;
                        eng_d.st   = ST_BIT;
                    end
                end else if (!rx_full) begin
                    eng_d.rcv  = 1'b1;
                    eng_d.bitn = 3'd7;
                    eng_d.half = 2'd0;
                    eng_d.st   = ST_BIT;
                end
            end
            ST_BIT: if (tick) begin
                if (eng_q.half == 2'd0) begin
                    eng_d.half = 2'd1;
                end else if (!eng_q.rcv && eng_q.sh[7] && !sda_in) begin
                    // another master holds SDA: withdraw without STOP
                    eng_d.st   = ST_IDLE;
                    eng_d.mode = 1'b0;
                end else begin
                    eng_d.sh   = {eng_q.sh[6:0], sda_in};
                    eng_d.half = 2'd0;
                    if (eng_q.bitn == 3'd0) eng_d.st   = ST_ACK;
                    else                    eng_d.bitn = eng_q.bitn - 3'd1;
                end
            end
            ST_ACK: if (tick) begin
                if (eng_q.half == 2'd0) begin
                    eng_d.half = 2'd1;
                end else begin
                    rx_push       = eng_q.rcv;
                    eng_d.addr_ph = 1'b0;
                    eng_d.st      = ST_LOAD;
                end
            end
            ST_STOP: if (tick) begin
                if (eng_q.half == 2'd2) eng_d.st   = ST_IDLE;
                else                    eng_d.half = eng_q.half + 2'd1;
            end
            default: ;
        endcase

        tx_flush = ctl_we && ctl_wdata[CB_EN] && ctl_wdata[CB_FLUSH];
        if (ctl_we) begin
            if (!ctl_wdata[CB_EN]) begin
                eng_d.mode = 1'b0;
                eng_d.st   = ST_IDLE;
                eng_d.div  = '0;
            end else begin
                eng_d.dir  = ctl_wdata[CB_DIR];
                eng_d.ackv = ctl_wdata[CB_ACK];
                if (!eng_q.mode && ctl_wdata[CB_MS]) begin
                    if (eng_q.st == ST_IDLE) begin
                        eng_d.mode = 1'b1;
                        eng_d.st   = ST_START;
                        eng_d.div  = '0;
                    end
                end else if (eng_q.mode && !ctl_wdata[CB_MS]) begin
                    eng_d.mode = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        case (eng_q.st)
            ST_START: sda_oe = 1'b1;
            ST_LOAD:  scl_oe = 1'b1;
            ST_BIT: begin
                scl_oe = (eng_q.half == 2'd0);
                sda_oe = !eng_q.rcv && !eng_q.sh[7];
            end
            ST_ACK: begin
                scl_oe = (eng_q.half == 2'd0);
                sda_oe = eng_q.rcv && !eng_q.ackv;
            end
            ST_STOP: begin
                scl_oe = (eng_q.half == 2'd0);
                sda_oe = (eng_q.half != 2'd2);
            end
            default: ;
        endcase
    end

    assign master_on = eng_q.mode;

endmodule

// File: rtl/i2c_fm_chk.sv
module i2c_fm_chk
    import i2c_fm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_we,
    input logic [CTL_W-1:0] ctl_wdata,
    input logic             scl_in,
    input logic             sda_in,
    input logic             tx_empty,
    input logic             tx_full,
    input logic             rx_empty,
    input logic             rx_full,
    input logic             bus_busy,
    input logic             master_on,
    input logic             scl_oe,
    input logic             sda_oe
);
    localparam logic [CTL_W-1:0] EN_MASK = CTL_W'(1) << CB_EN;

    // R9
    fifo_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_full && rx_empty) && !(tx_full && tx_empty));

    // R1
    disable_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ((ctl_wdata & EN_MASK) == '0)) |=> (!master_on && !scl_oe && !sda_oe));

    // R2
    start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(master_on) |-> (sda_oe && !scl_oe));

    // R4
    arb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(master_on) && !$past(ctl_we)) |-> (!scl_oe && !sda_oe));

    // R8
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_busy) |-> $past(scl_in && !sda_in));

endmodule

bind i2c_fifo_master i2c_fm_chk u_chk (.*);

// File: tb/test_i2c_fifo_master.sv
module test_i2c_fifo_master;
    localparam int HALF = 4;
    localparam logic [4:0] C_EN = 5'd1, C_MS = 5'd2, C_DIR = 5'd4, C_ACK = 5'd8, C_FL = 5'd16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ctl_we = 1'b0, tx_push = 1'b0, rx_pop = 1'b0;
    logic [4:0] ctl_wdata = '0;
    logic [7:0] tx_byte = '0, rx_byte;
    logic tx_empty, tx_full, rx_empty, rx_full, bus_busy, master_on, scl_oe, sda_oe;
    logic slv_drv = 1'b0;
    logic scl_bus, sda_bus;

    always #2 clk = ~clk;

    assign scl_bus = !scl_oe;
    assign sda_bus = !(sda_oe || slv_drv);

    i2c_fifo_master #(.HALF_DIV(HALF), .FIFO_DEPTH(16)) i_i2c_fifo_master (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .tx_push(tx_push), .tx_byte(tx_byte), .rx_pop(rx_pop), .rx_byte(rx_byte),
        .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty), .rx_full(rx_full),
        .bus_busy(bus_busy), .master_on(master_on), .scl_in(scl_bus), .sda_in(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    int tests = 0, fails = 0;
    int starts = 0, stops = 0, wr_seen = 0, rd_seen = 0, rd_mode = 0;
    bit arb_test = 1'b0;
    logic [7:0] exp_q[$];
    logic       ack_q[$];

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] slave_byte(input int idx);
        if (rd_mode == 1) return (idx == 1) ? 8'hC3 : 8'h5E;
        return 8'h80 | idx[7:0];
    endfunction

    // monitor: decodes the bus, plays the slave, compares against the scoreboard
    initial begin : monitor
        logic pscl, psda, s, dd;
        logic [7:0] sh, sb;
        int bitk, bidx;
        bit nacked;
        pscl = 1'b1; psda = 1'b1; sh = '0; bitk = 0; bidx = 0; nacked = 1'b0;
        forever begin
            @(negedge clk);
            s = scl_bus; dd = sda_bus;
            if (pscl && s && psda && !dd) begin
                starts++; bitk = 0; bidx = 0; nacked = 1'b0;
            end else if (pscl && s && !psda && dd) begin
                stops++; bitk = 0; slv_drv = 1'b0;
            end else if (!pscl && s) begin
                if (bitk < 8) begin
                    sh = {sh[6:0], dd};
                    bitk++;
                end else begin
                    if (rd_mode != 0 && bidx > 0) begin
                        rd_seen++;
                        if (dd) nacked = 1'b1;
                        if (ack_q.size() > 0) chk("R5 acknowledge level", int'(dd), int'(ack_q.pop_front()));
                    end else begin
                        wr_seen++;
                        if (exp_q.size() > 0) chk("R2 byte on bus", int'(sh), int'(exp_q.pop_front()));
                        else chk("R2 unexpected byte on bus", int'(sh), -1);
                    end
                    bitk = 0;
                    bidx++;
                end
            end else if (pscl && !s) begin
                if (bitk == 8) begin
                    slv_drv = !(rd_mode != 0 && bidx > 0);
                end else if (rd_mode != 0 && bidx > 0) begin
                    sb = slave_byte(bidx);
                    slv_drv = !nacked && !sb[7-bitk];
                end else begin
                    slv_drv = arb_test && bidx == 0 && bitk == 0;
                end
            end
            pscl = s; psda = dd;
        end
    end

    task automatic ctl(input logic [4:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic push(input logic [7:0] b, input bit on_bus);
        @(negedge clk); tx_push = 1'b1; tx_byte = b;
        if (on_bus) exp_q.push_back(b);
        @(negedge clk); tx_push = 1'b0;
    endtask

    task automatic pop(output logic [7:0] b);
        @(negedge clk); b = rx_byte; rx_pop = 1'b1;
        @(negedge clk); rx_pop = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : driver
        logic [7:0] b;
        int s0, p0, r0;
        wait_cyc(5); rst_n = 1'b1; wait_cyc(2);

        // reset state
        chk("R9 tx_empty at reset", tx_empty, 1);
        chk("R9 rx_empty at reset", rx_empty, 1);
        chk("R9 full flags at reset", {tx_full, rx_full}, 0);
        chk("R8 bus_busy at reset", bus_busy, 0);
        chk("R1 lines released at reset", {scl_oe, sda_oe, master_on}, 0);

        // R1: mode bit written without enable
        ctl(C_MS | C_DIR); wait_cyc(20);
        chk("R1 master_on stays low when disabled", master_on, 0);
        chk("R1 no START when disabled", starts, 0);

        // R9 / R7: fill and flush transmit FIFO
        for (int i = 0; i < 15; i++) push(8'(i), 1'b0);
        chk("R9 tx_full clear at 15", tx_full, 0);
        push(8'h0F, 1'b0);
        chk("R9 tx_full at 16", tx_full, 1);
        ctl(C_EN | C_FL);
        chk("R7 flush empties tx", {tx_empty, tx_full}, 2);

        // write transfer with address LSB 1 but transmit direction
        ctl(C_EN | C_DIR);
        push(8'hA5, 1'b1); push(8'h3C, 1'b1); push(8'h81, 1'b1);
        s0 = starts; p0 = stops;
        ctl(C_EN | C_MS | C_DIR); wait_cyc(3);
        chk("R2 master_on after mode rise", master_on, 1);
        chk("R8 bus_busy after START", bus_busy, 1);
        while (wr_seen < 3) @(negedge clk);
        wait_cyc(40);
        chk("R10 SCL held low on empty tx", scl_bus, 0);
        chk("R6 transmit despite address LSB", exp_q.size(), 0);
        push(8'hF0, 1'b1);
        while (wr_seen < 4) @(negedge clk);
        ctl(C_EN | C_DIR);
        while (stops == p0) @(negedge clk);
        wait_cyc(3);
        chk("R3 master_on low after STOP", master_on, 0);
        chk("R8 bus_busy cleared by STOP", bus_busy, 0);
        chk("R2 one START for transfer", starts - s0, 1);
        chk("R3 one STOP for transfer", stops - p0, 1);

        // read transfer: ACK first byte, NACK second
        rd_mode = 1;
        push(8'hA5, 1'b1);
        ack_q.push_back(1'b0); ack_q.push_back(1'b1);
        p0 = stops;
        ctl(C_EN | C_MS);
        while (rx_empty) @(negedge clk);
        ctl(C_EN | C_ACK);
        while (stops == p0) @(negedge clk);
        wait_cyc(3);
        pop(b); chk("R6 first received byte", b, 8'hC3);
        pop(b); chk("R6 second received byte", b, 8'h5E);
        chk("R9 rx_empty after draining", rx_empty, 1);
        chk("R5 all ack slots observed", ack_q.size(), 0);

        // R9: receive FIFO fills after exactly 16 bytes
        rd_mode = 2;
        push(8'hA5, 1'b1);
        r0 = rd_seen; p0 = stops;
        ctl(C_EN | C_MS);
        while (!rx_full) @(negedge clk);
        chk("R9 rx_full after 16 bytes", rd_seen - r0, 16);
        wait_cyc(40);
        chk("R9 SCL held low when rx full", scl_bus, 0);
        chk("R9 no byte beyond 16", rd_seen - r0, 16);
        ctl(C_EN);
        while (stops == p0) @(negedge clk);
        pop(b); chk("R6 first byte of long read", b, 8'h81);
        chk("R9 rx_full clears after one pop", rx_full, 0);
        for (int i = 2; i <= 16; i++) begin
            pop(b);
            if (b !== (8'h80 | 8'(i))) chk("R6 long read data", b, 8'h80 | 8'(i));
        end
        chk("R9 rx_empty after 16 pops", rx_empty, 1);

        // R4: arbitration loss on first address bit
        rd_mode = 0; arb_test = 1'b1;
        push(8'hA5, 1'b0);
        p0 = stops;
        ctl(C_EN | C_MS | C_DIR);
        wait_cyc(3);
        while (master_on) @(negedge clk);
        wait_cyc(10);
        chk("R4 master_on cleared", master_on, 0);
        chk("R4 lines released", {scl_oe, sda_oe}, 0);
        chk("R4 no STOP issued", stops - p0, 0);
        chk("R8 bus still busy under other master", bus_busy, 1);
        arb_test = 1'b0;
        @(negedge clk); slv_drv = 1'b0;
        wait_cyc(5);
        chk("R8 foreign STOP clears busy", bus_busy, 0);
        chk("R2 scoreboard drained", exp_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule